// File: doc/BRIEF.md
# Indirect Statistics Counter Access Engine

This block keeps a bank of 32-bit event counters for a group of MAC ports, six counters per port. The counters are not mapped into the host address space. A host reaches them through three 16-bit registers: a command register and two data staging registers. To start an operation, the host writes the command register with its start/busy flag set, along with an operation mode, a port index and a counter address. It then polls that flag until the engine clears it. The data staging registers hold the high and low halves of a 32-bit counter value.

There are four operations. A read copies one counter into the staging registers. A write loads one counter from the staging registers. A port clear zeroes the six counters of one port, one per cycle. A global clear zeroes every counter of every port, port by port. The MAC datapath supplies one increment strobe per counter. Each strobe adds one to its counter, and counters hold at the all-ones value once they reach it. Operations issued by the host take priority over increments that arrive in the same cycle.

Top module: `stat_cnt_engine`

## Requirements
- R1: After reset, the command register, both data staging registers and every counter read as zero.
- R2: The command register layout is as follows. Bits 4:0 hold the counter address. Bits 11:8 hold the port index. Bits 14:13 hold the mode (0 read, 1 write, 2 clear port, 3 clear all). Bit 15 is start/busy. Only the bits in mask 0x6F1F are stored, and all other bits read as zero. Writing with bit 15 clear stores the fields without starting an operation.
- R3: Register word offsets are the command register at 0x000, data bits 31:16 at 0x004 and data bits 15:0 at 0x008. Address bits 1:0 are ignored. Any other offset below 0x1000 reads as zero. Reads are combinational.
- R4: A read operation keeps busy high for exactly one cycle and copies the selected counter into the data registers. The counter with address a of port p is strobed by evt_i bit p*6+a. Addresses 0..5 are single collision, multiple collision, late collision, excessive collision, received pause and transmitted pause.
- R5: A write operation keeps busy high for exactly one cycle and loads the selected counter with {data high, data low}.
- R6: A port-clear operation keeps busy high for 6 cycles and zeroes all counters of the selected port. It ignores the address field and leaves the other ports unchanged.
- R7: A clear-all operation keeps busy high for 6*NUM_PORTS cycles and zeroes every counter. It ignores the port and address fields.
- R8: A command register write while busy is high has no effect on the command fields, on the operation in progress or on the data registers.
- R9: Each cycle in which a counter's event strobe is high adds one to that counter. A counter holding 0xFFFFFFFF stays there.
- R10: When an event strobe coincides with a host write or clear of the same counter, the host value wins and the event is dropped.
- R11: A read or write whose port is at or above NUM_PORTS, or whose address is at or above 6, completes in one cycle. A read returns zero in both data registers, and a write changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Host access strobe |
| bus_we_i | input | 1 | Host write enable |
| bus_addr_i | input | 12 | Host byte offset |
| bus_wdata_i | input | 16 | Host write data |
| bus_rdata_o | output | 16 | Host read data, combinational |
| evt_i | input | NUM_PORTS*6 | Per-counter increment strobes |

## Verification
The hardest situation to reach is a collision between the host and the event path: an increment strobe has to land in the exact cycle in which the sequencer writes or zeroes that same counter. That cycle sits one edge after the command write for a write, and one to six edges later for each counter of a port clear. To hit it, the stimulus drives the command write by hand and raises chosen strobes precisely in the execution cycle. Counters that are zeroed later in the same sweep also receive strobes, and so do counters on other ports. A command written during a long global clear covers the ignored-while-busy case. Random event bursts and random writes, checked against a bench model, cover normal counting, and directed writes near the all-ones value cover saturation.

// File: rtl/stat_cnt_pkg.sv
package stat_cnt_pkg;
  typedef enum logic [1:0] {
    OP_READ     = 2'd0,
    OP_WRITE    = 2'd1,
    OP_CLR_PORT = 2'd2,
    OP_CLR_ALL  = 2'd3
  } op_e;

  localparam int REG_W   = 16;
  localparam int CNT_W   = 2 * REG_W;
  localparam int ADDR_FW = 5;
  localparam int PORT_FW = 4;
  localparam int BUSY_BIT = 15;

  localparam logic [9:0] WORD_CMD = 10'd0;
  localparam logic [9:0] WORD_HI  = 10'd1;
  localparam logic [9:0] WORD_LO  = 10'd2;

  typedef struct packed {
    logic               busy;
    op_e                mode;
    logic [PORT_FW-1:0] port;
    logic [ADDR_FW-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/stat_host_regs.sv
module stat_host_regs
  import stat_cnt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [11:0]      bus_addr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             done_i,
  input  logic             rd_cap_i,
  input  logic [CNT_W-1:0] rd_val_i,
  output cmd_t             cmd_o,
  output logic             cmd_wr_o,
  output logic [CNT_W-1:0] wdata_o
);
  logic [9:0]       word;
  logic             wr;
  cmd_t             cmd_q;
  logic [REG_W-1:0] hi_q, lo_q;
  logic             unused_bits;

  assign word        = bus_addr_i[11:2];
  assign wr          = bus_req_i && bus_we_i;
  assign cmd_wr_o    = wr && (word == WORD_CMD);
  assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[12], bus_wdata_i[7:5]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (cmd_wr_o && !cmd_q.busy) begin
      cmd_q.busy <= bus_wdata_i[BUSY_BIT];
      cmd_q.mode <= op_e'(bus_wdata_i[14:13]);
      cmd_q.port <= bus_wdata_i[11:8];
      cmd_q.addr <= bus_wdata_i[4:0];
    end else if (done_i) begin
      cmd_q.busy <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (rd_cap_i) begin
      hi_q <= rd_val_i[CNT_W-1:REG_W];
      lo_q <= rd_val_i[REG_W-1:0];
    end else if (wr) begin
      if (word == WORD_HI) hi_q <= bus_wdata_i;
      if (word == WORD_LO) lo_q <= bus_wdata_i;
    end
  end

  always_comb begin
    unique case (word)
      WORD_CMD: bus_rdata_o = {cmd_q.busy, cmd_q.mode, 1'b0, cmd_q.port, 3'b000, cmd_q.addr};
      WORD_HI:  bus_rdata_o = hi_q;
      WORD_LO:  bus_rdata_o = lo_q;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign cmd_o   = cmd_q;
  assign wdata_o = {hi_q, lo_q};
endmodule

// File: rtl/stat_seq.sv
module stat_seq
  import stat_cnt_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int CNT_PER_PORT = 6,
  localparam int NUM_CNT = NUM_PORTS * CNT_PER_PORT,
  localparam int IDX_W   = $clog2(NUM_CNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_t             cmd_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             done_o,
  output logic             rd_cap_o,
  output logic             wr_en_o,
  output logic             tgt_ok_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0] wr_val_o
);
  logic [ADDR_FW-1:0] cl_addr_q;
  logic [PORT_FW-1:0] cl_port_q;
  logic [ADDR_FW-1:0] t_addr;
  logic [PORT_FW-1:0] t_port;
  logic               last_addr, last_port, is_clr;

  assign last_addr = (cl_addr_q == ADDR_FW'(CNT_PER_PORT - 1));
  assign last_port = (cl_port_q == PORT_FW'(NUM_PORTS - 1));
  assign is_clr    = (cmd_i.mode == OP_CLR_PORT) || (cmd_i.mode == OP_CLR_ALL);

  always_comb begin
    t_port = cmd_i.port;
    t_addr = cmd_i.addr;
    done_o = cmd_i.busy;
    unique case (cmd_i.mode)
      OP_CLR_PORT: begin
        t_addr = cl_addr_q;
        done_o = cmd_i.busy && last_addr;
      end
      OP_CLR_ALL: begin
        t_port = cl_port_q;
        t_addr = cl_addr_q;
        done_o = cmd_i.busy && last_addr && last_port;
      end
      default: ;
    endcase
  end

  assign tgt_ok_o = (32'(t_port) < NUM_PORTS) && (32'(t_addr) < CNT_PER_PORT);
  assign idx_o    = IDX_W'(32'(t_port) * CNT_PER_PORT + 32'(t_addr));
  assign wr_en_o  = cmd_i.busy && tgt_ok_o && (cmd_i.mode != OP_READ);
  assign wr_val_o = (cmd_i.mode == OP_WRITE) ? wdata_i : '0;
  assign rd_cap_o = cmd_i.busy && (cmd_i.mode == OP_READ);

  // sweep position for bulk clears, parked at zero when idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cl_addr_q <= '0;
      cl_port_q <= '0;
    end else if (!cmd_i.busy || !is_clr) begin
      cl_addr_q <= '0;
      cl_port_q <= '0;
    end else if (last_addr) begin
      cl_addr_q <= '0;
      cl_port_q <= cl_port_q + 1'b1;
    end else begin
      cl_addr_q <= cl_addr_q + 1'b1;
    end
  end
endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import stat_cnt_pkg::*;
#(
  parameter int NUM_CNT = 24,
  localparam int IDX_W  = $clog2(NUM_CNT)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CNT-1:0]       evt_i,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [CNT_W-1:0]         wr_val_i,
  output logic [CNT_W-1:0]         rd_val_o,
  output logic [NUM_CNT*CNT_W-1:0] cnt_flat_o
);
  logic [CNT_W-1:0] cnt_q [NUM_CNT];

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cnt_q[k] <= '0;
      else if (wr_en_i && (32'(idx_i) == k))
        cnt_q[k] <= wr_val_i;
      else if (evt_i[k] && (cnt_q[k] != '1))
        cnt_q[k] <= cnt_q[k] + 1'b1;
    end
    assign cnt_flat_o[k*CNT_W +: CNT_W] = cnt_q[k];
  end

  assign rd_val_o = (32'(idx_i) < NUM_CNT) ? cnt_q[idx_i] : '0;
endmodule

// File: rtl/stat_cnt_engine.sv
module stat_cnt_engine
  import stat_cnt_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int CNT_PER_PORT = 6
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              bus_req_i,
  input  logic                              bus_we_i,
  input  logic [11:0]                       bus_addr_i,
  input  logic [15:0]                       bus_wdata_i,
  output logic [15:0]                       bus_rdata_o,
  input  logic [NUM_PORTS*CNT_PER_PORT-1:0] evt_i
);
  localparam int NUM_CNT = NUM_PORTS * CNT_PER_PORT;
  localparam int IDX_W   = $clog2(NUM_CNT);

  cmd_t                     cmd;
  logic                     cmd_wr, done, rd_cap, wr_en, tgt_ok;
  logic [IDX_W-1:0]         idx;
  logic [CNT_W-1:0]         wdata, wr_val, bank_rd, rd_val;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic                     busy;
  logic [1:0]               mode;
  logic [12:0]              fields;

  assign busy   = cmd.busy;
  assign mode   = cmd.mode;
  assign fields = {cmd.mode, cmd.port, cmd.addr, 2'b00};
  assign rd_val = tgt_ok ? bank_rd : '0;

  stat_host_regs u_regs (
    .clk_i, .rst_ni, .bus_req_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .done_i(done), .rd_cap_i(rd_cap), .rd_val_i(rd_val),
    .cmd_o(cmd), .cmd_wr_o(cmd_wr), .wdata_o(wdata)
  );

  stat_seq #(.NUM_PORTS(NUM_PORTS), .CNT_PER_PORT(CNT_PER_PORT)) u_seq (
    .clk_i, .rst_ni, .cmd_i(cmd), .wdata_i(wdata),
    .done_o(done), .rd_cap_o(rd_cap), .wr_en_o(wr_en), .tgt_ok_o(tgt_ok),
    .idx_o(idx), .wr_val_o(wr_val)
  );

  stat_bank #(.NUM_CNT(NUM_CNT)) u_bank (
    .clk_i, .rst_ni, .evt_i, .wr_en_i(wr_en), .idx_i(idx), .wr_val_i(wr_val),
    .rd_val_o(bank_rd), .cnt_flat_o(cnt_flat)
  );
endmodule

// File: rtl/stat_cnt_engine_chk.sv
module stat_cnt_engine_chk #(
  parameter int NUM_PORTS    = 4,
  parameter int CNT_PER_PORT = 6,
  localparam int NUM_CNT = NUM_PORTS * CNT_PER_PORT,
  localparam int IDX_W   = $clog2(NUM_CNT),
  localparam int LEN_ALL = NUM_CNT,
  localparam int RUN_W   = $clog2(LEN_ALL + 2)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  busy,
  input logic [1:0]            mode,
  input logic [12:0]           fields,
  input logic                  cmd_wr,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      idx,
  input logic [31:0]           wr_val,
  input logic [NUM_CNT*32-1:0] cnt_flat
);
  logic [RUN_W-1:0] run_q;
  logic [IDX_W-1:0] last_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= '0;
      last_idx_q <= '0;
    end else begin
      run_q      <= busy ? run_q + 1'b1 : '0;
      last_idx_q <= idx;
    end
  end

  // R4 R5
  p_rw_one_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy) && !mode[1]) |=> !busy);

  p_clrport_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && mode == 2'd2) |-> run_q == RUN_W'(CNT_PER_PORT));

  p_clrall_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && mode == 2'd3) |-> run_q == RUN_W'(LEN_ALL));

  p_ignore_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_wr) |=> $stable(fields));

  // R10: host value lands regardless of strobes
  p_host_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> cnt_flat[32'(last_idx_q)*32 +: 32] == $past(wr_val));

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_sat
    p_saturate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_flat[k*32 +: 32] == 32'hFFFF_FFFF && !(wr_en && 32'(idx) == k))
      |=> cnt_flat[k*32 +: 32] == 32'hFFFF_FFFF);
  end
endmodule

bind stat_cnt_engine stat_cnt_engine_chk #(.NUM_PORTS(NUM_PORTS), .CNT_PER_PORT(CNT_PER_PORT)) u_chk (
  .clk_i, .rst_ni, .busy, .mode, .fields, .cmd_wr, .wr_en, .idx, .wr_val, .cnt_flat
);

// File: tb/sim_stat_cnt_engine.sv
module sim_stat_cnt_engine;
  localparam int NP = 4;
  localparam int CP = 6;
  localparam int NC = NP * CP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [NC-1:0] evt = '0;

  logic [31:0] mdl [NC];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  stat_cnt_engine #(.NUM_PORTS(NP), .CNT_PER_PORT(CP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_i(evt)
  );

  function automatic logic [15:0] mk_cmd(logic go, logic [1:0] m, logic [3:0] p, logic [4:0] a);
    return {go, m, 1'b0, p, 3'b000, a};
  endfunction

  function automatic logic [31:0] sat_inc(logic [31:0] v);
    return (v == 32'hFFFF_FFFF) ? v : v + 1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [15:0] d);
    addr = a; req = 1'b1; we = 1'b0;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic poll(inout int n);
    logic [15:0] d;
    for (int i = 0; i < 400; i++) begin
      bus_rd(12'h000, d);
      if (!d[15]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic launch(logic [15:0] c, output int n);
    n = 0;
    bus_wr(12'h000, c);
    poll(n);
  endtask

  // command write, then strobe v during the first execution cycle
  task automatic launch_evt(logic [15:0] c, logic [NC-1:0] v, output int n);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 12'h000; wdata = c;
    @(negedge clk);
    req = 1'b0; we = 1'b0; evt = v;
    @(negedge clk);
    evt = '0;
    n = 1;
    poll(n);
  endtask

  task automatic rd_cnt(int p, int a, output logic [31:0] v, output int n);
    logic [15:0] h, l;
    launch(mk_cmd(1'b1, 2'd0, 4'(p), 5'(a)), n);
    bus_rd(12'h004, h);
    bus_rd(12'h008, l);
    v = {h, l};
  endtask

  task automatic wr_cnt(int p, int a, logic [31:0] v, output int n);
    bus_wr(12'h004, v[31:16]);
    bus_wr(12'h008, v[15:0]);
    launch(mk_cmd(1'b1, 2'd1, 4'(p), 5'(a)), n);
    if (p < NP && a < CP) mdl[p*CP+a] = v;
  endtask

  task automatic pulse(logic [NC-1:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
    for (int k = 0; k < NC; k++) if (v[k]) mdl[k] = sat_inc(mdl[k]);
  endtask

  task automatic cmp_all(string tag);
    logic [31:0] v;
    int n;
    for (int k = 0; k < NC; k++) begin
      rd_cnt(k / CP, k % CP, v, n);
      chk(tag, v, mdl[k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: all requirements, actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [31:0] v;
    int n;
    void'($urandom(32'd20240611));
    for (int k = 0; k < NC; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    bus_rd(12'h000, d); chk("R1 cmd", 32'(d), 0);
    bus_rd(12'h004, d); chk("R1 data hi", 32'(d), 0);
    bus_rd(12'h008, d); chk("R1 data lo", 32'(d), 0);
    cmp_all("R1 counter");

    // R2
    bus_wr(12'h000, 16'h7FFF);
    bus_rd(12'h000, d); chk("R2 mask", 32'(d), 32'h6F1F);
    bus_wr(12'h000, 16'h0000);
    bus_rd(12'h000, d); chk("R2 clear", 32'(d), 0);

    // R3
    bus_wr(12'h006, 16'h1234);
    bus_rd(12'h004, d); chk("R3 hi", 32'(d), 32'h1234);
    bus_rd(12'h007, d); chk("R3 low bits", 32'(d), 32'h1234);
    bus_wr(12'h00B, 16'hBEEF);
    bus_rd(12'h008, d); chk("R3 lo", 32'(d), 32'hBEEF);
    bus_rd(12'h00C, d); chk("R3 unmapped", 32'(d), 0);
    bus_rd(12'hFFC, d); chk("R3 top", 32'(d), 0);

    // R5 R4
    wr_cnt(2, 3, 32'hDEAD_BEEF, n); chk("R5 busy len", 32'(n), 1);
    rd_cnt(2, 3, v, n);
    chk("R4 busy len", 32'(n), 1);
    chk("R4 read value", v, 32'hDEAD_BEEF);

    // R9 random event bursts
    for (int i = 0; i < 60; i++) pulse(NC'($urandom) & NC'($urandom));
    cmp_all("R9 counting");

    // R5 random writes mixed with events
    for (int i = 0; i < 20; i++) begin
      int p, a;
      p = int'($urandom % NP); a = int'($urandom % CP);
      wr_cnt(p, a, $urandom, n);
      pulse(NC'($urandom));
      rd_cnt(p, a, v, n);
      chk("R5 random write", v, mdl[p*CP+a]);
    end

    // R9 saturation
    wr_cnt(1, 0, 32'hFFFF_FFFE, n);
    for (int i = 0; i < 3; i++) pulse(NC'(1) << 6);
    rd_cnt(1, 0, v, n); chk("R9 saturate", v, 32'hFFFF_FFFF);

    // R10 write versus same-cycle event
    bus_wr(12'h004, 16'h0000);
    bus_wr(12'h008, 16'h0005);
    launch_evt(mk_cmd(1'b1, 2'd1, 4'd0, 5'd1), NC'(1) << 1, n);
    mdl[1] = 32'd5;
    rd_cnt(0, 1, v, n); chk("R10 write wins", v, 32'd5);

    // R6 port clear, address field ignored
    pulse('1);
    launch(mk_cmd(1'b1, 2'd2, 4'd1, 5'd5), n);
    chk("R6 busy len", 32'(n), 6);
    for (int a = 0; a < CP; a++) mdl[CP+a] = '0;
    cmp_all("R6 port clear");

    // R10 R6 events during port clear of port 0
    launch_evt(mk_cmd(1'b1, 2'd2, 4'd0, 5'd0), (NC'(1) << 0) | (NC'(1) << 5) | (NC'(1) << 12), n);
    chk("R6 busy len evt", 32'(n), 6);
    for (int a = 0; a < CP; a++) mdl[a] = '0;
    mdl[12] = sat_inc(mdl[12]);
    cmp_all("R10 clear wins");

    // R7 clear all, port and address ignored
    pulse('1);
    launch(mk_cmd(1'b1, 2'd3, 4'd9, 5'd7), n);
    chk("R7 busy len", 32'(n), NC);
    for (int k = 0; k < NC; k++) mdl[k] = '0;
    cmp_all("R7 clear all");

    // R8 command write during busy
    pulse('1);
    bus_wr(12'h004, 16'hAAAA);
    bus_wr(12'h008, 16'h5555);
    bus_wr(12'h000, mk_cmd(1'b1, 2'd3, 4'd9, 5'd7));
    bus_wr(12'h000, mk_cmd(1'b1, 2'd0, 4'd1, 5'd1));
    n = 0;
    poll(n);
    for (int k = 0; k < NC; k++) mdl[k] = '0;
    bus_rd(12'h000, d); chk("R8 cmd kept", 32'(d), 32'h6907);
    bus_rd(12'h004, d); chk("R8 hi kept", 32'(d), 32'hAAAA);
    bus_rd(12'h008, d); chk("R8 lo kept", 32'(d), 32'h5555);

    // R11 out-of-range targets
    pulse('1);
    rd_cnt(5, 2, v, n);
    chk("R11 read busy", 32'(n), 1);
    chk("R11 read zero", v, 0);
    wr_cnt(0, 6, 32'h0BAD_F00D, n);
    chk("R11 write busy", 32'(n), 1);
    cmp_all("R11 no change");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule